// File: doc/BRIEF.md
# Quick Increment/Decrement Flag Unit

This unit performs the arithmetic step of a read-modify-write instruction that adds a small constant to a memory operand, or subtracts one from it. The operand read from memory arrives with a 3-bit step code, a size select (byte or word), a direction select (increment or decrement) and the current condition flags. One clock later the unit presents the value to write back, the updated flags and the cycle cost of the operation.

The step code gives the amount: codes 1 to 7 are used as they are, and code 0 stands for 8. The carry flag is not touched by this operation. Overflow comes from a change of sign between operand and result. Half-carry compares the low nibble of the operand with the full step amount.

Top module: `quick_step_unit`

## Requirements
- R1: The step amount equals `step_code` for codes 1 to 7, and equals 8 for code 0.
- R2: `wb_data` is the operand plus the amount (increment) or minus the amount (decrement), modulo 2^16 in word mode. In byte mode only `operand[7:0]` is used, the sum wraps modulo 2^8, and `wb_data[15:8]` is 0.
- R3: The zero flag `flags_out[4]` is 1 exactly when the result, at the selected size, is zero.
- R4: The sign flag `flags_out[5]` equals bit 7 of the result in byte mode and bit 15 in word mode.
- R5: The subtract flag `flags_out[1]` is 0 after an increment and 1 after a decrement.
- R6: The half flag `flags_out[3]` is 1 on an increment when the operand's low nibble plus the amount is greater than 15, and on a decrement when the low nibble is smaller than the amount (a borrow out of bit 3).
- R7: The overflow flag `flags_out[2]` is 1 on an increment only when the operand was non-negative and the result is negative, and on a decrement only when the operand was negative and the result is non-negative, at the selected size.
- R8: The carry flag `flags_out[0]` equals `flags_in[0]`. Bits 5 to 1 of `flags_in` have no effect on any output.
- R9: An accepted request (`in_valid` high) yields `out_valid` high on the next cycle, with `cost_out` = 6 for both sizes. On cycles without a request, `wb_data`, `flags_out` and `cost_out` keep their values.
- R10: A synchronous reset clears `out_valid`, `wb_data`, `flags_out` and `cost_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| step_code | input | 3 | Step amount code, 0 means 8 |
| word_mode | input | 1 | 1 selects a 16-bit operand, 0 selects 8 bits |
| dec_mode | input | 1 | 1 subtracts, 0 adds |
| operand | input | 16 | Value read from memory |
| flags_in | input | 6 | Current flags {S,Z,H,V,N,C} |
| out_valid | output | 1 | Result valid |
| wb_data | output | 16 | Value to write back |
| flags_out | output | 6 | Updated flags {S,Z,H,V,N,C} |
| cost_out | output | 4 | Cycle cost of the operation |

## Verification
On every cycle the assertions tie the registered outputs to each other and to the inputs of the previous cycle: the one-cycle latency and the cost, the zero upper byte in byte mode, agreement of the sign and zero flags with the written value, the subtract flag with the direction, the carry with its input, the sign direction that overflow implies, and the holding of outputs when no request comes. The amount decode, exact result values, the half-carry boundary on both sides, and whether overflow is raised at all show up only in the bench's vectors. The same holds for the reset values and for the fact that the other input flags are ignored.

// File: rtl/quick_step_pkg.sv
package quick_step_pkg;
  localparam int FLAG_W = 6;
  localparam int F_S = 5;
  localparam int F_Z = 4;
  localparam int F_H = 3;
  localparam int F_V = 2;
  localparam int F_N = 1;
  localparam int F_C = 0;

  typedef struct packed {
    logic s;
    logic z;
    logic h;
    logic v;
    logic n;
    logic c;
  } step_flags_t;
endpackage

// File: rtl/quick_step_amount.sv
module quick_step_amount #(
  parameter int IMM_W = 3,
  localparam int AMT_W = IMM_W + 1
) (
  input  logic [IMM_W-1:0] code,
  output logic [AMT_W-1:0] amount
);
  always_comb begin
    if (code == '0) amount = AMT_W'(1 << IMM_W);
    else            amount = AMT_W'(code);
  end
endmodule

// File: rtl/quick_step_arith.sv
module quick_step_arith #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int AMT_W  = 4,
  localparam int NIB_W = 4
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  amount,
  input  logic              dec_mode,
  input  logic              word_mode,
  output logic [DATA_W-1:0] result,
  output logic              sign_old,
  output logic              sign_new,
  output logic              is_zero,
  output logic              half
);
  logic [DATA_W-1:0] amt_ext;
  logic [DATA_W-1:0] full;
  logic [BYTE_W-1:0] narrow;
  logic [NIB_W:0]    nib_sum;
  logic [NIB_W-1:0]  nib;

  always_comb begin
    amt_ext = DATA_W'(amount);
    full    = dec_mode ? (operand - amt_ext) : (operand + amt_ext);
    narrow  = full[BYTE_W-1:0];
    result  = word_mode ? full : DATA_W'(narrow);
  end

  always_comb begin
    sign_old = word_mode ? operand[DATA_W-1] : operand[BYTE_W-1];
    sign_new = word_mode ? full[DATA_W-1]    : narrow[BYTE_W-1];
    is_zero  = word_mode ? (full == '0)      : (narrow == '0);
  end

  always_comb begin
    nib     = operand[NIB_W-1:0];
    nib_sum = (NIB_W+1)'(nib) + (NIB_W+1)'(amount);
    if (dec_mode) half = ((NIB_W+1)'(nib) < (NIB_W+1)'(amount));
    else          half = (nib_sum > (NIB_W+1)'({NIB_W{1'b1}}));
  end
endmodule

// File: rtl/quick_step_flags.sv
module quick_step_flags
  import quick_step_pkg::*;
(
  input  logic        dec_mode,
  input  logic        sign_old,
  input  logic        sign_new,
  input  logic        is_zero,
  input  logic        half,
  input  logic        carry_in,
  output step_flags_t flags
);
  always_comb begin
    flags.s = sign_new;
    flags.z = is_zero;
    flags.h = half;
    flags.n = dec_mode;
    flags.c = carry_in;
    if (dec_mode) flags.v = sign_old & ~sign_new;
    else          flags.v = ~sign_old & sign_new;
  end
endmodule

// File: rtl/quick_step_unit.sv
module quick_step_unit
  import quick_step_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 3,
  parameter int CYC_W  = 4,
  parameter int COST   = 6,
  localparam int AMT_W = IMM_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [IMM_W-1:0]  step_code,
  input  logic              word_mode,
  input  logic              dec_mode,
  input  logic [DATA_W-1:0] operand,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] wb_data,
  output logic [FLAG_W-1:0] flags_out,
  output logic [CYC_W-1:0]  cost_out
);
  logic [AMT_W-1:0]  amount;
  logic [DATA_W-1:0] result;
  logic              sign_old, sign_new, is_zero, half;
  step_flags_t       next_flags;

  quick_step_amount #(.IMM_W(IMM_W)) u_amount (
    .code   (step_code),
    .amount (amount)
  );

  quick_step_arith #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .AMT_W(AMT_W)) u_arith (
    .operand   (operand),
    .amount    (amount),
    .dec_mode  (dec_mode),
    .word_mode (word_mode),
    .result    (result),
    .sign_old  (sign_old),
    .sign_new  (sign_new),
    .is_zero   (is_zero),
    .half      (half)
  );

  quick_step_flags u_flags (
    .dec_mode (dec_mode),
    .sign_old (sign_old),
    .sign_new (sign_new),
    .is_zero  (is_zero),
    .half     (half),
    .carry_in (flags_in[F_C]),
    .flags    (next_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wb_data   <= '0;
      flags_out <= '0;
      cost_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wb_data   <= result;
        flags_out <= next_flags;
        cost_out  <= CYC_W'(COST);
      end
    end
  end
endmodule

// File: rtl/quick_step_unit_chk.sv
module quick_step_unit_chk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 3,
  parameter int CYC_W  = 4,
  parameter int COST   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [IMM_W-1:0]  step_code,
  input logic              word_mode,
  input logic              dec_mode,
  input logic [DATA_W-1:0] operand,
  input logic [5:0]        flags_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] wb_data,
  input logic [5:0]        flags_out,
  input logic [CYC_W-1:0]  cost_out
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid && !rst)); // R9
  AST_COST_SIX: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> cost_out == CYC_W'(COST)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !out_valid) |=> ($stable(wb_data) && $stable(flags_out))); // R9
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(word_mode)) |-> wb_data[DATA_W-1:BYTE_W] == '0); // R2
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> flags_out[4] == (wb_data == '0)); // R3
  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> flags_out[5] == ($past(word_mode) ? wb_data[DATA_W-1] : wb_data[BYTE_W-1])); // R4
  AST_SUB_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> flags_out[1] == $past(dec_mode)); // R5
  AST_OVF_SIGN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flags_out[2]) |-> flags_out[5] == !flags_out[1]); // R7
  AST_CARRY_PASS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> flags_out[0] == $past(flags_in[0])); // R8
endmodule

bind quick_step_unit quick_step_unit_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .IMM_W(IMM_W), .CYC_W(CYC_W), .COST(COST)
) u_chk (.*);

// File: tb/tb_quick_step_unit.sv
`timescale 1ns/1ps
module tb_quick_step_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  step_code;
  logic        word_mode;
  logic        dec_mode;
  logic [15:0] operand;
  logic [5:0]  flags_in;
  logic        out_valid;
  logic [15:0] wb_data;
  logic [5:0]  flags_out;
  logic [3:0]  cost_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quick_step_unit dut (.*);

  // {dec, word, code, operand, flags_in, exp_data, exp_flags}; flags {S,Z,H,V,N,C}
  localparam int NV = 13;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd1, 16'h0000, 6'h00, 16'h0001, 6'h00},
    {1'b0, 1'b0, 3'd0, 16'h007F, 6'h01, 16'h0087, 6'h2D},  // R1 code 0, R7 inc ovf
    {1'b0, 1'b0, 3'd1, 16'h00FF, 6'h00, 16'h0000, 6'h18},  // R3 byte wrap
    {1'b1, 1'b0, 3'd1, 16'h0080, 6'h3F, 16'h007F, 6'h0F},  // R7 dec ovf, R8
    {1'b1, 1'b0, 3'd5, 16'h0005, 6'h00, 16'h0000, 6'h12},  // R6 no borrow at equal
    {1'b1, 1'b0, 3'd0, 16'h0003, 6'h00, 16'h00FB, 6'h2A},
    {1'b0, 1'b1, 3'd7, 16'h7FFC, 6'h00, 16'h8003, 6'h2C},
    {1'b0, 1'b1, 3'd2, 16'hFFFE, 6'h01, 16'h0000, 6'h19},
    {1'b1, 1'b1, 3'd3, 16'h8001, 6'h00, 16'h7FFE, 6'h0E},
    {1'b1, 1'b1, 3'd4, 16'h0000, 6'h00, 16'hFFFC, 6'h2A},
    {1'b0, 1'b0, 3'd3, 16'hAB10, 6'h00, 16'h0013, 6'h00},  // R2 upper byte ignored
    {1'b0, 1'b1, 3'd6, 16'h1234, 6'h3E, 16'h123A, 6'h00},  // R8 other flags ignored
    {1'b1, 1'b1, 3'd1, 16'h0010, 6'h00, 16'h000F, 6'h0A}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic d, input logic w, input logic [2:0] c,
                       input logic [15:0] op, input logic [5:0] fi);
    @(negedge clk);
    in_valid = 1'b1; dec_mode = d; word_mode = w; step_code = c;
    operand = op; flags_in = fi;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_all(input logic [15:0] ed, input logic [5:0] ef);
    chk("R9 out_valid", int'(out_valid), 1);
    chk("R2 wb_data", int'(wb_data), int'(ed));
    chk("R4 S", int'(flags_out[5]), int'(ef[5]));
    chk("R3 Z", int'(flags_out[4]), int'(ef[4]));
    chk("R6 H", int'(flags_out[3]), int'(ef[3]));
    chk("R7 V", int'(flags_out[2]), int'(ef[2]));
    chk("R5 N", int'(flags_out[1]), int'(ef[1]));
    chk("R8 C", int'(flags_out[0]), int'(ef[0]));
    chk("R9 cost", int'(cost_out), 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; step_code = '0; word_mode = 1'b0;
    dec_mode = 1'b0; operand = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", int'(out_valid), 0);
    chk("R10 wb_data", int'(wb_data), 0);
    chk("R10 flags", int'(flags_out), 0);
    chk("R10 cost", int'(cost_out), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][48], VEC[i][47], VEC[i][46:44], VEC[i][43:28], VEC[i][27:22]);
      check_all(VEC[i][21:6], VEC[i][5:0]);
    end

    // R1 code 0 adds 8, code 7 adds 7
    issue(1'b0, 1'b0, 3'd0, 16'h0010, 6'h00);
    chk("R1 code0", int'(wb_data), 16'h0018);
    issue(1'b0, 1'b1, 3'd7, 16'h0100, 6'h00);
    chk("R1 code7", int'(wb_data), 16'h0107);

    // R6 increment boundary: nibble+amount == 15 gives H=0
    issue(1'b0, 1'b0, 3'd7, 16'h0008, 6'h00);
    chk("R6 H edge", int'(flags_out[3]), 0);

    // R9 outputs hold while no request
    @(negedge clk);
    operand = 16'hFFFF; dec_mode = 1'b1; word_mode = 1'b1; flags_in = 6'h3F;
    repeat (2) @(negedge clk);
    chk("R9 valid low", int'(out_valid), 0);
    chk("R9 hold data", int'(wb_data), 16'h000F);
    chk("R9 hold flags", int'(flags_out), 6'h00);

    // R10 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R10 clr data", int'(wb_data), 0);
    chk("R10 clr cost", int'(cost_out), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule